// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of input pins, split into fixed groups of equal width. Each group has one sticky interrupt flag. A pin change in either direction on any pin that the group's mask enables sets that flag. Each pin is captured by a transparent latch that is open while the clock is low. Two flops then synchronize it. A toggle is recognized when the two synchronized stages differ. The detection is registered once more before it reaches the flag.

Software programs each group's mask through a one-hot write strobe. It clears flags by pulsing a write-one-to-clear vector. A per-group enable gates each flag onto its interrupt request output. A combined wake output compares the raw pins directly against the last synchronized values. It can therefore announce activity while the clock is stopped. The block samples its pins as inputs whatever drives them, so a pin that the rest of the chip drives still triggers and can serve as a software interrupt.

Top module: `pin_change_irq_ctrl`

## Requirements
- R1: After reset all flags, interrupt requests and the wake output are 0, and every mask bit is 0.
- R2: Pin i belongs to group i / GROUP_WIDTH (pins 0-7 to group 0, 8-15 to group 1, 16-23 to group 2 at default size), and a change on it can set only that group's flag bit flags_o[i / GROUP_WIDTH].
- R3: A rising change and a falling change on an enabled pin each set the group flag.
- R4: A change on a pin whose mask bit is 0 leaves the flag at 0.
- R5: If a pin changes while the clock is low, the flag is still 0 after the second following rising edge and is 1 after the third.
- R6: A set flag stays at 1 until flag_clr_i has its bit at 1 at a rising edge. Then it reads 0 from that edge on.
- R7: When a new detection and a clear reach the same flag at the same edge, the flag stays 1.
- R8: irq_o[g] is 1 exactly when flags_o[g] is 1 and irq_en_i[g] was 1 at the edge that last updated the outputs.
- R9: Writing a mask (mask_we_i bit g with mask_wdata_i) while the pins are steady sets no flag.
- R10: wake_o goes to 1 without any clock edge when an enabled pin differs from its last synchronized value. It stays at 1 while the clock is stopped, and it returns to 0 once the pin has been synchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the input latch is open while it is low |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_GROUPS*GROUP_WIDTH | Monitored pins |
| mask_we_i | input | NUM_GROUPS | One-hot mask write strobe per group |
| mask_wdata_i | input | GROUP_WIDTH | Mask value to write |
| irq_en_i | input | NUM_GROUPS | Per-group interrupt enable |
| flag_clr_i | input | NUM_GROUPS | Write-one-to-clear flag pulse |
| flags_o | output | NUM_GROUPS | Sticky per-group change flags |
| irq_o | output | NUM_GROUPS | Registered flag AND enable |
| wake_o | output | 1 | Unclocked wake request |

## Verification
The bench builds the block at its default size of three groups of eight pins. At this size the group boundaries at pins 7/8 and 15/16, and the top pin 23, can all be driven and checked for crosstalk into a neighbouring group's flag. The bench can also stop its clock, so the wake path is observed with no edges at all. It then checks that the same change still reaches the flag once the clock resumes.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int unsigned DEF_GROUPS = 3;
  localparam int unsigned DEF_WIDTH  = 8;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

  function automatic flag_op_e flag_op(input logic set, input logic clr);
    if (set)      return FLAG_SET;
    else if (clr) return FLAG_CLEAR;
    else          return FLAG_HOLD;
  endfunction
endpackage

// File: rtl/pcx_pin_sync.sv
module pcx_pin_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] first_o,
  output logic [WIDTH-1:0] second_o
);
  logic [WIDTH-1:0] held;

  // transparent while clk is low, frozen while high
  always_latch begin
    if (rst)       held = '0;
    else if (!clk) held = raw_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_o  <= '0;
      second_o <= '0;
    end else begin
      first_o  <= held;
      second_o <= first_o;
    end
  end
endmodule

// File: rtl/pcx_group.sv
module pcx_group
  import pcx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] first_i,
  input  logic [WIDTH-1:0] second_i,
  input  logic             mask_we_i,
  input  logic [WIDTH-1:0] mask_wdata_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [WIDTH-1:0] mask_q;
  logic             det_q;
  logic             change_now;
  logic             flag_d;

  assign change_now = |((first_i ^ second_i) & mask_q);
  assign wake_o     = |((raw_i ^ second_i) & mask_q);

  always_comb begin
    unique case (flag_op(det_q, clr_i))
      FLAG_SET:   flag_d = 1'b1;
      FLAG_CLEAR: flag_d = 1'b0;
      default:    flag_d = flag_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      det_q  <= 1'b0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      det_q  <= change_now;
      flag_o <= flag_d;
      irq_o  <= flag_d & en_i;
    end
  end

  // R3: a flag only rises after a registered detection
  a_r3_rise_needs_detect: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(det_q));
  // R6: a clear with no detection empties the flag
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !det_q) |=> !flag_o);
  // R7: detection wins over clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    det_q |=> flag_o);
  // R8: request implies a pending flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
endmodule

// File: rtl/pin_change_irq_ctrl.sv
module pin_change_irq_ctrl #(
  parameter int unsigned NUM_GROUPS  = pcx_pkg::DEF_GROUPS,
  parameter int unsigned GROUP_WIDTH = pcx_pkg::DEF_WIDTH
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] pins_i,
  input  logic [NUM_GROUPS-1:0]             mask_we_i,
  input  logic [GROUP_WIDTH-1:0]            mask_wdata_i,
  input  logic [NUM_GROUPS-1:0]             irq_en_i,
  input  logic [NUM_GROUPS-1:0]             flag_clr_i,
  output logic [NUM_GROUPS-1:0]             flags_o,
  output logic [NUM_GROUPS-1:0]             irq_o,
  output logic                              wake_o
);
  localparam int unsigned NPINS = NUM_GROUPS * GROUP_WIDTH;

  logic [NPINS-1:0]      sync_a;
  logic [NPINS-1:0]      sync_b;
  logic [NUM_GROUPS-1:0] wake_g;

  pcx_pin_sync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .raw_i    (pins_i),
    .first_o  (sync_a),
    .second_o (sync_b)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pcx_group #(.WIDTH(GROUP_WIDTH)) u_grp (
      .clk          (clk),
      .rst          (rst),
      .raw_i        (pins_i[g*GROUP_WIDTH +: GROUP_WIDTH]),
      .first_i      (sync_a[g*GROUP_WIDTH +: GROUP_WIDTH]),
      .second_i     (sync_b[g*GROUP_WIDTH +: GROUP_WIDTH]),
      .mask_we_i    (mask_we_i[g]),
      .mask_wdata_i (mask_wdata_i),
      .en_i         (irq_en_i[g]),
      .clr_i        (flag_clr_i[g]),
      .flag_o       (flags_o[g]),
      .irq_o        (irq_o[g]),
      .wake_o       (wake_g[g])
    );
  end

  assign wake_o = |wake_g;

  // R1: reset leaves nothing pending
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (flags_o == '0 && irq_o == '0));
  // R9: with a steady pin bank, no flag can newly rise two edges later
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    ($stable(pins_i) && $past($stable(pins_i)) && $past($stable(pins_i), 2)
     && $past($stable(pins_i), 3) && $past(!rst, 3))
    |-> (flags_o & ~$past(flags_o)) == '0);
endmodule

// File: tb/pin_change_irq_ctrl_test.sv
module pin_change_irq_ctrl_test;
  localparam int G = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst;
  logic [G*W-1:0] pins;
  logic [G-1:0]   mask_we, irq_en, clr;
  logic [W-1:0]   mask_wd;
  logic [G-1:0]   flags, irq;
  logic           wake;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = clk_run ? ~clk : clk;

  pin_change_irq_ctrl #(.NUM_GROUPS(G), .GROUP_WIDTH(W)) uut (
    .clk(clk), .rst(rst), .pins_i(pins), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wd), .irq_en_i(irq_en), .flag_clr_i(clr),
    .flags_o(flags), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic set_mask(input int g, input logic [W-1:0] m);
    @(negedge clk); mask_we = '0; mask_we[g] = 1'b1; mask_wd = m;
    @(negedge clk); mask_we = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = '1;
    @(negedge clk); clr = '0;
  endtask

  task automatic flip(input int p);
    @(negedge clk); pins[p] = ~pins[p];
  endtask

  task automatic t_reset();
    edges(1);
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);
    flip(2); edges(4);
    check("R1 mask cleared", flags, 0);
  endtask

  task automatic t_latency_edges();
    set_mask(0, 8'h08);
    flip(3); edges(2);
    check("R5 not yet", flags[0], 0);
    edges(1);
    check("R5 after third edge", flags[0], 1);
    check("R3 rising", flags, 3'b001);
    clear_all(); edges(1);
    check("R6 cleared", flags[0], 0);
    flip(3); edges(4);
    check("R3 falling", flags[0], 1);
    edges(5);
    check("R6 sticky", flags[0], 1);
    clear_all(); edges(1);
  endtask

  task automatic t_groups();
    set_mask(0, 8'h80); set_mask(1, 8'h81); set_mask(2, 8'h80);
    flip(8); edges(4);
    check("R2 pin 8 group1", flags, 3'b010);
    clear_all();
    flip(7); edges(4);
    check("R2 pin 7 group0", flags, 3'b001);
    clear_all();
    flip(23); edges(4);
    check("R2 pin 23 group2", flags, 3'b100);
    clear_all();
    flip(16); edges(4);
    check("R4 masked pin 16", flags, 3'b000);
    flip(15); edges(4);
    check("R2 pin 15 group1", flags, 3'b010);
    clear_all(); edges(1);
  endtask

  task automatic t_mask_write();
    set_mask(2, 8'hFF); edges(4);
    check("R9 mask write", flags, 0);
    set_mask(2, 8'h00); edges(4);
    check("R9 mask clear", flags, 0);
  endtask

  task automatic t_collision();
    set_mask(1, 8'h02);
    flip(9); edges(4);
    check("R7 preset", flags[1], 1);
    flip(9); @(posedge clk); @(posedge clk);
    @(negedge clk); clr = 3'b010;
    @(negedge clk); clr = '0;
    check("R7 set beats clear", flags[1], 1);
    clear_all(); edges(1);
    check("R6 clear alone", flags[1], 0);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_en = 3'b010;
    flip(9); edges(4);
    check("R8 enabled", irq, 3'b010);
    @(negedge clk); irq_en = '0; edges(1);
    check("R8 disabled", irq, 0);
    check("R8 flag held", flags[1], 1);
    clear_all(); edges(1);
  endtask

  task automatic t_wake();
    set_mask(0, 8'h01);
    @(negedge clk); clk_run = 1'b0;
    #3; pins[0] = ~pins[0]; #1;
    check("R10 wake no clock", wake, 1);
    #60;
    check("R10 wake held", wake, 1);
    check("R10 no flag yet", flags[0], 0);
    clk_run = 1'b1;
    edges(4);
    check("R10 wake drops", wake, 0);
    check("R10 flag after restart", flags[0], 1);
    clear_all(); edges(1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pins = '0; mask_we = '0; mask_wd = '0; irq_en = '0; clr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_latency_edges();
    t_groups();
    t_mask_write();
    t_collision();
    t_irq();
    t_wake();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule